// File: doc/BRIEF.md
# Indirect RAM Access Host Interface

This block sits between a byte-wide synchronous host bus and a 512-word by 16-bit internal memory that the host cannot address directly. The host stages a 16-bit word in two byte registers and the low eight address bits in a third register. It then starts a transfer with a single write to a control register. That one write carries the ninth address bit, the transfer direction and a request flag.

The request flag reads back as 1 for a fixed number of clock cycles, set by a parameter. When the flag clears, the transfer is complete. A read has loaded the fetched word into the two byte registers, and a write has stored the staged word. Completion also raises a sticky RAM-done status bit. If the host writes 0 to the request flag before completion, the transfer is cancelled.

Receive and transmit events arrive as single-cycle strobes and set their own sticky status bits. Each of the three status bits is gated by an enable bit in the control register. The three gated bits are merged onto one interrupt line.

Top module: `ram_host_if`

## Requirements
- R1: After reset, every host register reads 0x00, the interrupt output is low, and the read-data output is 0x00.
- R2: The host-bus register offsets are: offset 0 holds the data low byte, offset 1 the data high byte, offset 2 the address low byte, offset 3 the control register and offset 4 the status register. A read returns the register value on the read-data output one clock after the read strobe is sampled. Offsets 0, 1 and 2 read back the value last written to them.
- R3: A control write with bit 2 = 1 (write direction) and bit 1 = 1 (request) stores {data high, data low} into the memory word at {control bit 0, address low} when the transfer completes.
- R4: A control write with bit 2 = 0 and bit 1 = 1 loads the memory word at {control bit 0, address low} into the data registers when the transfer completes. While the transfer is pending, reads of the data registers return their earlier contents.
- R5: Control bit 1 reads 1 for exactly LAT_CYCLES clock cycles after the starting control write, then reads 0. Completion sets status bit 5 (RAM done).
- R6: A control write with bit 1 = 0 while a transfer is pending cancels it. The memory is left unchanged, status bit 5 is not set, and control bit 1 reads 0 afterwards.
- R7: A receive strobe sets status bit 6 and a transmit strobe sets status bit 7. Status bits stay set until the host writes 1 to that bit position at offset 4. Writing 0 leaves a status bit unchanged.
- R8: The interrupt output is high exactly when any status bit is set together with its enable. The enables are control bit 5 for RAM done, bit 6 for receive and bit 7 for transmit.
- R9: Control bit 0 is the ninth address bit, so words at the same address low byte with bit 0 = 0 and bit 0 = 1 are distinct locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 3 | Host register offset |
| hostWdata | input | 8 | Host write data |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostRdata | output | 8 | Registered host read data |
| rxEvent | input | 1 | Single-cycle receive event strobe |
| txEvent | input | 1 | Single-cycle transmit event strobe |
| hostIrq | output | 1 | Merged, enable-gated interrupt |

## Verification
The bench builds the block with LAT_CYCLES = 8 rather than the default of 25000. With this short latency, the request flag can be sampled on the last busy cycle and on the first idle cycle. It also lets a cancel land partway through a pending transfer. Both halves of the address space are written and read back at the same low address. Each interrupt source is exercised with its enable off and with it on.

// File: rtl/ram_host_pkg.sv
package ram_host_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 1 << ADDR_W;

  localparam logic [2:0] OFS_DLO  = 3'd0;
  localparam logic [2:0] OFS_DHI  = 3'd1;
  localparam logic [2:0] OFS_ALO  = 3'd2;
  localparam logic [2:0] OFS_CTRL = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd4;

  typedef struct packed {
    logic start;
    logic commit;
  } ctrlStrobes_t;
endpackage

// File: rtl/rhi_control.sv
module rhi_control
  import ram_host_pkg::*;
#(
  parameter int LAT_CYCLES = 25000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ctrlWr,
  input  logic         reqBit,
  output logic         busy,
  output ctrlStrobes_t strb
);
  localparam int CNT_W = $clog2(LAT_CYCLES + 1);

  logic [CNT_W-1:0] waitCnt;
  logic             lastCycle;

  assign lastCycle   = busy && (waitCnt == '0);
  assign strb.commit = lastCycle;
  assign strb.start  = !busy && ctrlWr && reqBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      waitCnt <= '0;
    end else if (busy) begin
      if (lastCycle) begin
        busy <= 1'b0;
      end else if (ctrlWr && !reqBit) begin
        busy    <= 1'b0;
        waitCnt <= '0;
      end else begin
        waitCnt <= waitCnt - 1'b1;
      end
    end else if (strb.start) begin
      busy    <= 1'b1;
      waitCnt <= CNT_W'(LAT_CYCLES - 1);
    end
  end
endmodule

// File: rtl/rhi_datapath.sv
module rhi_datapath
  import ram_host_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   hostAddr,
  input  logic [7:0]   hostWdata,
  input  logic         hostWr,
  input  logic         hostRd,
  input  logic         rxEvent,
  input  logic         txEvent,
  input  logic         busy,
  input  ctrlStrobes_t strb,
  output logic [7:0]   hostRdata,
  output logic [2:0]   statusBits,
  output logic [2:0]   enableBits,
  output logic         hostIrq
);
  logic [7:0]        dataLo, dataHi, addrLo;
  logic              rwSel, addrMsb;
  logic [ADDR_W-1:0] accAddr;
  logic              accWrite;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [2:0]        statSet, statClr;
  logic [7:0]        rdMux;

  assign statSet = {txEvent, rxEvent, strb.commit};
  assign statClr = (hostWr && hostAddr == OFS_STAT) ? hostWdata[7:5] : 3'b000;
  assign hostIrq = |(statusBits & enableBits);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataLo     <= '0;
      dataHi     <= '0;
      addrLo     <= '0;
      rwSel      <= 1'b0;
      addrMsb    <= 1'b0;
      enableBits <= '0;
      statusBits <= '0;
      accAddr    <= '0;
      accWrite   <= 1'b0;
    end else begin
      statusBits <= (statusBits & ~statClr) | statSet;
      if (hostWr) begin
        unique case (hostAddr)
          OFS_DLO:  dataLo <= hostWdata;
          OFS_DHI:  dataHi <= hostWdata;
          OFS_ALO:  addrLo <= hostWdata;
          OFS_CTRL: begin
            enableBits <= hostWdata[7:5];
            rwSel      <= hostWdata[2];
            addrMsb    <= hostWdata[0];
          end
          default: ;
        endcase
      end
      if (strb.start) begin
        accAddr  <= {hostWdata[0], addrLo};
        accWrite <= hostWdata[2];
      end
      if (strb.commit && !accWrite) begin
        {dataHi, dataLo} <= mem[accAddr];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.commit && accWrite) begin
      mem[accAddr] <= {dataHi, dataLo};
    end
  end

  always_comb begin
    unique case (hostAddr)
      OFS_DLO:  rdMux = dataLo;
      OFS_DHI:  rdMux = dataHi;
      OFS_ALO:  rdMux = addrLo;
      OFS_CTRL: rdMux = {enableBits[2], enableBits[1], enableBits[0],
                         2'b00, rwSel, busy, addrMsb};
      OFS_STAT: rdMux = {statusBits, 5'b00000};
      default:  rdMux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) hostRdata <= '0;
    else if (hostRd) hostRdata <= rdMux;
  end
endmodule

// File: rtl/ram_host_if.sv
module ram_host_if
  import ram_host_pkg::*;
#(
  parameter int LAT_CYCLES = 25000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] hostAddr,
  input  logic [7:0] hostWdata,
  input  logic       hostWr,
  input  logic       hostRd,
  output logic [7:0] hostRdata,
  input  logic       rxEvent,
  input  logic       txEvent,
  output logic       hostIrq
);
  ctrlStrobes_t strb;
  logic         busy;
  logic         ctrlWr;
  logic [2:0]   statusBits, enableBits;

  assign ctrlWr = hostWr && (hostAddr == OFS_CTRL);

  rhi_control #(.LAT_CYCLES(LAT_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .reqBit(hostWdata[1]),
    .busy(busy), .strb(strb)
  );

  rhi_datapath i_dp (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostWr(hostWr), .hostRd(hostRd), .rxEvent(rxEvent), .txEvent(txEvent),
    .busy(busy), .strb(strb), .hostRdata(hostRdata),
    .statusBits(statusBits), .enableBits(enableBits), .hostIrq(hostIrq)
  );
endmodule

// File: rtl/rhi_checker.sv
module rhi_checker
  import ram_host_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       ctrlWr,
  input logic [7:0] hostWdata,
  input logic [2:0] hostAddr,
  input logic       hostWr,
  input logic       rxEvent,
  input logic       busy,
  input logic       commit,
  input logic [2:0] statusBits,
  input logic [2:0] enableBits,
  input logic       hostIrq
);
  logic rxClear;
  assign rxClear = hostWr && hostAddr == OFS_STAT && hostWdata[6];

  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> statusBits[0]); // R5

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !commit && !(ctrlWr && !hostWdata[1])) |=> busy); // R5

  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> !busy); // R5

  AST_CANCEL_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctrlWr && !hostWdata[1]) |=> !busy); // R6

  AST_RX_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statusBits[1] && !rxClear) |=> statusBits[1]); // R7

  AST_RX_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (rxEvent && enableBits[1] && !(ctrlWr && !hostWdata[6])) |=> hostIrq); // R8
endmodule

bind ram_host_if rhi_checker i_chk (
  .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .hostWdata(hostWdata),
  .hostAddr(hostAddr), .hostWr(hostWr), .rxEvent(rxEvent), .busy(busy),
  .commit(strb.commit), .statusBits(statusBits), .enableBits(enableBits),
  .hostIrq(hostIrq)
);

// File: tb/test_ram_host_if.sv
module test_ram_host_if;
  localparam int LAT = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic       hostWr = 1'b0;
  logic       hostRd = 1'b0;
  logic [7:0] hostRdata;
  logic       rxEvent = 1'b0;
  logic       txEvent = 1'b0;
  logic       hostIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ram_host_if #(.LAT_CYCLES(LAT)) i_ram_host_if (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostWr(hostWr), .hostRd(hostRd), .hostRdata(hostRdata),
    .rxEvent(rxEvent), .txEvent(txEvent), .hostIrq(hostIrq)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0; hostWdata = '0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    hostAddr = a; hostRd = 1'b1;
    @(negedge clk);
    hostRd = 1'b0;
    d = hostRdata;
  endtask

  task automatic pulse(input bit isTx);
    if (isTx) txEvent = 1'b1; else rxEvent = 1'b1;
    @(negedge clk);
    txEvent = 1'b0; rxEvent = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 5; a++) begin
      busRead(3'(a), v);
      chk($sformatf("R1 reset offset %0d", a), v, 8'h00);
    end
    chk("R1 reset irq", {7'd0, hostIrq}, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    busWrite(3'd0, 8'h5A); busWrite(3'd1, 8'hC3); busWrite(3'd2, 8'h7E);
    busRead(3'd0, v); chk("R2 data low", v, 8'h5A);
    busRead(3'd1, v); chk("R2 data high", v, 8'hC3);
    busRead(3'd2, v); chk("R2 addr low", v, 8'h7E);
  endtask

  task automatic doWrite(input logic msb, input logic [15:0] w, input string tag);
    logic [7:0] v;
    busWrite(3'd0, w[7:0]); busWrite(3'd1, w[15:8]); busWrite(3'd2, 8'h12);
    busWrite(3'd3, {5'b00000, 1'b1, 1'b1, msb});
    waitCycles(LAT - 1);
    busRead(3'd3, v); chk({tag, " R5 req on last busy cycle"}, v & 8'h02, 8'h02);
    busRead(3'd3, v); chk({tag, " R5 req cleared"}, v & 8'h02, 8'h00);
    busRead(3'd4, v); chk({tag, " R5 done status"}, v, 8'h20);
    chk({tag, " R8 irq masked"}, {7'd0, hostIrq}, 8'h00);
    busWrite(3'd4, 8'h20);
    busRead(3'd4, v); chk({tag, " R7 done cleared"}, v, 8'h00);
  endtask

  task automatic doRead(input logic msb, input logic [15:0] exp, input string tag);
    logic [7:0] v;
    busWrite(3'd0, 8'h11); busWrite(3'd1, 8'h22); busWrite(3'd2, 8'h12);
    busWrite(3'd3, {7'b0000000, msb});
    busWrite(3'd3, {5'b00000, 1'b0, 1'b1, msb});
    busRead(3'd0, v); chk({tag, " R4 pending low keeps old"}, v, 8'h11);
    busRead(3'd1, v); chk({tag, " R4 pending high keeps old"}, v, 8'h22);
    waitCycles(LAT);
    busRead(3'd3, v); chk({tag, " R5 req cleared"}, v & 8'h02, 8'h00);
    busRead(3'd0, v); chk({tag, " R4 low byte"}, v, exp[7:0]);
    busRead(3'd1, v); chk({tag, " R4 high byte"}, v, exp[15:8]);
    busWrite(3'd4, 8'h20);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    busWrite(3'd0, 8'hFF); busWrite(3'd1, 8'hFF); busWrite(3'd2, 8'h12);
    busWrite(3'd3, 8'h06);
    waitCycles(2);
    busWrite(3'd3, 8'h04);
    busRead(3'd3, v); chk("R6 req reads 0 after cancel", v & 8'h02, 8'h00);
    waitCycles(LAT + 2);
    busRead(3'd4, v); chk("R6 no done status", v, 8'h00);
    doRead(1'b0, 16'hA53C, "R6 memory unchanged");
  endtask

  task automatic t_irq();
    logic [7:0] v;
    busWrite(3'd3, 8'h20);
    pulse(1'b0);
    busRead(3'd4, v); chk("R7 rx sets bit 6", v, 8'h40);
    chk("R8 rx not enabled", {7'd0, hostIrq}, 8'h00);
    busWrite(3'd4, 8'h00);
    busRead(3'd4, v); chk("R7 write 0 keeps rx", v, 8'h40);
    busWrite(3'd3, 8'h40);
    chk("R8 rx enabled irq", {7'd0, hostIrq}, 8'h01);
    busWrite(3'd4, 8'h40);
    chk("R8 irq drops after clear", {7'd0, hostIrq}, 8'h00);
    busRead(3'd4, v); chk("R7 rx cleared", v, 8'h00);
    pulse(1'b1);
    busRead(3'd4, v); chk("R7 tx sets bit 7", v, 8'h80);
    chk("R8 tx not enabled", {7'd0, hostIrq}, 8'h00);
    busWrite(3'd3, 8'h80);
    chk("R8 tx enabled irq", {7'd0, hostIrq}, 8'h01);
    busWrite(3'd4, 8'h80);
    busWrite(3'd3, 8'h22);
    waitCycles(LAT + 1);
    chk("R8 ram done irq", {7'd0, hostIrq}, 8'h01);
    busWrite(3'd4, 8'h20);
    chk("R8 irq low after done clear", {7'd0, hostIrq}, 8'h00);
  endtask

  initial begin
    waitCycles(4);
    rstN = 1'b1;
    waitCycles(1);
    t_reset();
    t_regs();
    doWrite(1'b0, 16'hA53C, "R3 lower half");
    doWrite(1'b1, 16'h6B90, "R9 upper half");
    doRead(1'b0, 16'hA53C, "R4 lower half");
    doRead(1'b1, 16'h6B90, "R9 upper half read");
    t_abort();
    t_irq();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule